// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external static RAM that has no clock of its own, organised as 262,144 words of 4 bits. The host issues one request at a time over a valid/ready handshake: an 18-bit word address, a write flag and, for writes, a 4-bit data word. Reads return a 4-bit word together with a valid strobe that lasts one clock.

On the memory side the controller drives three active-low strobes: chip select, output enable and write enable. It also drives the address bus and a bidirectional data bus. The data bus is presented as separate out, in and drive-enable signals, and the pad sits outside the block. Writes are timed by the write-enable strobe, and output enable stays inactive for the whole of a write. Each phase lasts a whole number of clock cycles. That number is found by rounding the memory's nanosecond limits up against the clock period, so the same logic works at any clock rate. The controller hands the data bus back and forth with explicit turnaround cycles, so the controller and the memory never drive it at the same time.

Top module: `async_sram_ctrl`

## Requirements
- R1: Out of reset and whenever idle, chip select, output enable and write enable are all high (1 = inactive), the data bus is not driven (`sram_dq_oe` = 0), `req_ready` is 1 and `rsp_valid` is 0.
- R2: A write request (`req_write` = 1) drives the address, chip select low and write enable low, with the write data on the bus and output enable high. Write enable stays low for exactly WP cycles, where WP is the ceiling of the largest of write-pulse width, data setup and cycle time over the clock period, and at least 1.
- R3: In the cycle after write enable rises, the address and the write data are unchanged and the bus is still driven. This gives one cycle of hold.
- R4: In the cycle after that hold cycle, the data bus is released and chip select is high. One turnaround cycle follows before the controller is idle again. A write therefore keeps `req_ready` low for WP+2 cycles after acceptance.
- R5: A read request drives the address with chip select and output enable low for AC cycles. AC is the ceiling of the largest of address access, output-enable access and cycle time over the clock period, and at least 1. The bus is sampled at the end of the last of those cycles and returned on `rsp_rdata`, with `rsp_valid` high for exactly one cycle.
- R6: When `rsp_valid` is high, output enable and chip select are already high again. They stay high for OFF cycles before the next request can start, where OFF is the ceiling of the output turn-off time over the clock period, and at least 1. A read keeps `req_ready` low for AC+OFF cycles.
- R7: The controller never drives the data bus while output enable is low.
- R8: Requests are taken only while `req_ready` is 1. A request presented while busy causes no memory cycle and no response.
- R9: At the default 20 ns clock with the fastest memory grade, WP = AC = OFF = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 4 | Read data |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_addr | output | 18 | Memory address bus |
| sram_dq_out | output | 4 | Data to memory |
| sram_dq_in | input | 4 | Data from memory |
| sram_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The assertions assume that the host holds its address, write flag and data steady only up to the edge where the request is taken, and never later. They also assume that the memory answers within the access limit of the configured parameters. The bench drives requests on falling edges and drops them right after acceptance, apart from one deliberate request made while the controller is busy. Its memory model returns data as soon as it is selected and stores a word only when write enable rises. Because of that, a pulse that is too short or data that is not held shows up as a mismatch or a timing failure.

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 4,
  parameter int CLK_NS   = 20,
  parameter int T_WP_NS  = 12,
  parameter int T_DS_NS  = 7,
  parameter int T_AA_NS  = 15,
  parameter int T_OE_NS  = 6,
  parameter int T_HZ_NS  = 6,
  parameter int T_RC_NS  = 15,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);

  localparam int WR_NS0  = (T_WP_NS > T_DS_NS) ? T_WP_NS : T_DS_NS;
  localparam int WR_NS   = (WR_NS0 > T_RC_NS) ? WR_NS0 : T_RC_NS;
  localparam int RD_NS0  = (T_AA_NS > T_OE_NS) ? T_AA_NS : T_OE_NS;
  localparam int RD_NS   = (RD_NS0 > T_RC_NS) ? RD_NS0 : T_RC_NS;
  localparam int WP_RAW  = (WR_NS + CLK_NS - 1) / CLK_NS;
  localparam int AC_RAW  = (RD_NS + CLK_NS - 1) / CLK_NS;
  localparam int OFF_RAW = (T_HZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_CYC  = (WP_RAW  < 1) ? 1 : WP_RAW;
  localparam int AC_CYC  = (AC_RAW  < 1) ? 1 : AC_RAW;
  localparam int OFF_CYC = (OFF_RAW < 1) ? 1 : OFF_RAW;
  localparam int TRN_CYC = (TURN_CYC < 1) ? 1 : TURN_CYC;

  typedef enum logic [2:0] {
    S_IDLE, S_WPULSE, S_WHOLD, S_WTURN, S_RWAIT, S_ROFF
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_done;

  assign req_ready = (state == S_IDLE);
  assign cnt_done  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      sram_ce_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            sram_addr <= req_addr;
            sram_ce_n <= 1'b0;
            if (req_write) begin
              state       <= S_WPULSE;
              sram_we_n   <= 1'b0;
              sram_dq_out <= req_wdata;
              sram_dq_oe  <= 1'b1;
              cnt         <= CNT_W'(WP_CYC - 1);
            end else begin
              state     <= S_RWAIT;
              sram_oe_n <= 1'b0;
              cnt       <= CNT_W'(AC_CYC - 1);
            end
          end
        end
        S_WPULSE: begin
          if (cnt_done) begin
            sram_we_n <= 1'b1;
            state     <= S_WHOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WHOLD: begin
          sram_dq_oe <= 1'b0;
          sram_ce_n  <= 1'b1;
          cnt        <= CNT_W'(TRN_CYC - 1);
          state      <= S_WTURN;
        end
        S_WTURN: begin
          if (cnt_done) state <= S_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        S_RWAIT: begin
          if (cnt_done) begin
            rsp_rdata <= sram_dq_in;
            rsp_valid <= 1'b1;
            sram_oe_n <= 1'b1;
            sram_ce_n <= 1'b1;
            cnt       <= CNT_W'(OFF_CYC - 1);
            state     <= S_ROFF;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ROFF: begin
          if (cnt_done) state <= S_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] wl_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wl_len <= '0;
    else if (!sram_we_n) wl_len <= wl_len + 1'b1;
    else                 wl_len <= '0;
  end

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

  p_wr_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (wl_len == CNT_W'(WP_CYC)));

  p_wr_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dq_oe));

  p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> ($stable(sram_addr) && $stable(sram_dq_out) && sram_dq_oe));

  p_bus_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |=> (!sram_dq_oe && sram_ce_n));

  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (sram_oe_n && sram_ce_n));

  p_oe_after_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n) |-> $past(!sram_dq_oe));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);

endmodule

// File: tb/async_sram_ctrl_test.sv
module async_sram_ctrl_test;
  localparam int AW = 18;
  localparam int DW = 4;
  localparam int CLK_NS = 20;
  localparam int WP  = (15 + CLK_NS - 1) / CLK_NS;
  localparam int AC  = (15 + CLK_NS - 1) / CLK_NS;
  localparam int OFF = (6 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_dq_out, sram_dq_in;

  always #(CLK_NS/2) clk = ~clk;

  async_sram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
    .sram_dq_oe(sram_dq_oe)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [int];
  logic [DW-1:0] exp_mem [int];
  logic [DW-1:0] exp_q [$];
  int wl = 0, pulses = 0, writes = 0, contention = 0, unexpected = 0;
  bit post_rise = 0;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_data;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : '0;
  endfunction

  always_comb sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem_word(sram_addr) : '0;

  always @(negedge clk) if (rst_n) begin
    if (post_rise) begin
      check(!sram_dq_oe && sram_ce_n, "R4", "bus released after hold", {sram_dq_oe, sram_ce_n}, 2'b01);
      post_rise = 0;
    end
    if (!sram_oe_n && sram_dq_oe) contention++;
    if (!sram_we_n) begin
      wl++;
      cur_addr = sram_addr;
      cur_data = sram_dq_out;
    end else if (wl > 0) begin
      check(wl == WP, "R2", "write pulse cycles", wl, WP);
      check(sram_dq_oe && sram_dq_out == cur_data && sram_addr == cur_addr, "R3",
            "hold of data and address", {sram_dq_oe, sram_dq_out}, {1'b1, cur_data});
      mem[int'(cur_addr)] = cur_data;
      pulses++;
      wl = 0;
      post_rise = 1;
    end
    if (rsp_valid) begin
      if (exp_q.size() == 0) unexpected++;
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rsp_rdata == e, "R5", "read data", rsp_rdata, e);
        check(sram_oe_n && sram_ce_n, "R6", "strobes released at response", {sram_oe_n, sram_ce_n}, 2'b11);
      end
    end
  end

  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, output int n);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) begin exp_mem[int'(a)] = d; writes++; end
    else exp_q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : '0);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!req_ready) begin @(negedge clk); n++; end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    int n;
    issue(1'b1, a, d, n);
    check(n == WP + 3, "R9", "write busy span", n, WP + 3);
  endtask

  task automatic do_read(logic [AW-1:0] a);
    int n;
    issue(1'b0, a, '0, n);
    check(n == AC + OFF + 1, "R9", "read busy span", n, AC + OFF + 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready && !rsp_valid,
          "R1", "reset state", {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready, rsp_valid}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    check(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R1", "idle after reset",
          {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);

    do_write(18'h00000, 4'hA);
    do_write(18'h3FFFF, 4'h5);
    do_write(18'h12345, 4'hF);
    do_write(18'h00001, 4'h0);
    do_read(18'h00000);
    do_read(18'h3FFFF);
    do_read(18'h12345);
    do_read(18'h00001);
    do_read(18'h2AAAA);
    do_write(18'h12345, 4'h3);
    do_read(18'h12345);
    do_read(18'h12345);
    for (int i = 0; i < 8; i++) begin
      do_write(AW'(i * 4099), DW'(i * 3 + 1));
      do_read(AW'(i * 4099));
    end

    // R8: a second request raised while the first write is still busy
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00777; req_wdata = 4'h6;
    exp_mem[int'(18'h00777)] = 4'h6; writes++;
    @(negedge clk);
    req_addr = 18'h00000; req_wdata = 4'h9;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8", "controller busy during overlap request", req_ready, 0);
    do_read(18'h00000);
    do_read(18'h00777);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R5", "all responses returned", exp_q.size(), 0);
    check(unexpected == 0, "R8", "no response without request", unexpected, 0);
    check(pulses == writes, "R8", "write pulses match accepted writes", pulses, writes);
    check(contention == 0, "R7", "bus driven while output enabled", contention, 0);
    finish_run();
  end
endmodule